// File: doc/BRIEF.md
# Floating-Point NaN Propagation Selector

This block sits beside a single-precision floating-point datapath and settles what happens when NaNs arrive at its inputs. For each operation it looks at one or two 32-bit operands and reports whether the result must be a propagated NaN. If it must, the block says which operand supplies that NaN and returns it in quiet form. It also raises the invalid-operation flag whenever a signaling NaN was consumed. The arithmetic unit uses the NaN result in place of its own result whenever `nan_out` is high.

Two propagation conventions are supported, chosen per operation by `conv_mode`:

- **Legacy stack convention:** a quiet NaN outranks a signaling one. Between two NaNs of the same kind, the larger fraction wins.
- **Vector convention:** whenever both operands are NaNs, the first operand always wins.

A unary/binary select restricts the decision to the first operand only. The parameter `REG_OUT` picks between a combinational result and a result held in an output register. The default is the registered variant.

The block has no sequencing of its own. There are no states or transitions: the only storage is the optional output register, which follows its inputs every clock.

Top module: `nan_prop_select`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero. `nan_out` is high exactly when at least one considered operand is a NaN.
- R2: The NaN result equals the chosen operand with bit 22 (the quiet bit) forced to 1. Every other bit of the chosen operand, sign included, is copied unchanged.
- R3: `invalid` is high exactly when at least one considered operand is a signaling NaN, meaning a NaN whose bit 22 is 0.
- R4: When exactly one of the two operands is a NaN, that NaN is returned in quiet form. This holds in both conventions.
- R5: With `conv_mode`=1 (vector) and both operands NaN, operand A is returned in quiet form.
- R6: With `conv_mode`=0 (legacy), when one operand is a signaling NaN and the other a quiet NaN, the quiet operand is returned.
- R7: With `conv_mode`=0 and both operands NaNs of the same kind, the operand whose bits 22:0 form the larger unsigned value is returned, in quiet form. On equal fractions, operand A is returned.
- R8: With `unary`=1, only operand A is considered. Operand B has no effect on any output.
- R9: When no considered operand is a NaN, `nan_out`=0, `invalid`=0 and `nan_res`=0.
- R10: With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_mode | input | 1 | 0 = legacy stack convention, 1 = vector convention |
| unary | input | 1 | 1 = single-operand operation (operand A only) |
| opa | input | 32 | First operand, single precision |
| opb | input | 32 | Second operand, single precision |
| nan_out | output | 1 | Result must be the propagated NaN |
| nan_res | output | 32 | Quieted NaN result, zero when nan_out is low |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions assume the registered variant. They also assume that every input is a known value at each rising edge after reset, since results are related to the inputs one cycle earlier.

The bench meets both conditions. It drives all inputs only on falling edges and holds defined values from time zero, including during reset. Its operands are drawn from ordinary numbers, infinities, signaling NaNs and quiet NaNs, with deliberate fraction ties. In unary cases, operand B is often a signaling NaN, so that ignoring B shows up at the outputs.

// File: rtl/nanp_pkg.sv
package nanp_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int QBIT   = FRAC_W - 1;
    localparam int EXP_LO = FRAC_W;
    localparam int EXP_HI = FRAC_W + EXP_W - 1;

    typedef enum logic {
        CONV_STACK  = 1'b0,
        CONV_VECTOR = 1'b1
    } conv_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } nan_class_t;
endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
    import nanp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output nan_class_t        cls,
    output logic [WORD_W-1:0] quieted
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones    = &word[EXP_HI:EXP_LO];
        frac_nz     = |word[FRAC_W-1:0];
        cls.is_nan  = exp_ones && frac_nz;
        cls.is_snan = exp_ones && frac_nz && !word[QBIT];
        quieted     = word;
        quieted[QBIT] = 1'b1;
    end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
    import nanp_pkg::*;
(
    input  nan_class_t        cls_a,
    input  nan_class_t        cls_b,
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    input  conv_e             conv,
    input  logic              unary,
    output logic              hit,
    output logic              take_b,
    output logic              inv
);
    logic b_nan;
    logic b_snan;
    logic b_larger;

    always_comb begin
        b_nan    = cls_b.is_nan && !unary;
        b_snan   = cls_b.is_snan && !unary;
        b_larger = frac_b > frac_a;
        hit      = cls_a.is_nan || b_nan;
        inv      = cls_a.is_snan || b_snan;
        take_b   = 1'b0;
        if (b_nan) begin
            if (!cls_a.is_nan) begin
                take_b = 1'b1;
            end else begin
                unique case (conv)
                    CONV_VECTOR: take_b = 1'b0;
                    CONV_STACK: begin
                        if (cls_a.is_snan != cls_b.is_snan)
                            take_b = cls_a.is_snan;
                        else
                            take_b = b_larger;
                    end
                    default: take_b = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/nan_prop_select.sv
module nan_prop_select
    import nanp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_mode,
    input  logic              unary,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              nan_out,
    output logic [WORD_W-1:0] nan_res,
    output logic              invalid
);
    nan_class_t        cls_a;
    nan_class_t        cls_b;
    logic [WORD_W-1:0] q_a;
    logic [WORD_W-1:0] q_b;
    logic              hit;
    logic              take_b;
    logic              inv;
    logic [WORD_W-1:0] res_c;
    conv_e             conv;

    assign conv = conv_e'(conv_mode);

    nanp_classify u_cls_a (.word(opa), .cls(cls_a), .quieted(q_a));
    nanp_classify u_cls_b (.word(opb), .cls(cls_b), .quieted(q_b));

    nanp_pick u_pick (
        .cls_a (cls_a),
        .cls_b (cls_b),
        .frac_a(opa[FRAC_W-1:0]),
        .frac_b(opb[FRAC_W-1:0]),
        .conv  (conv),
        .unary (unary),
        .hit   (hit),
        .take_b(take_b),
        .inv   (inv)
    );

    always_comb begin
        if (!hit)
            res_c = '0;
        else if (take_b)
            res_c = q_b;
        else
            res_c = q_a;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    nan_out <= 1'b0;
                    nan_res <= '0;
                    invalid <= 1'b0;
                end else begin
                    nan_out <= hit;
                    nan_res <= res_c;
                    invalid <= inv;
                end
            end
        end else begin : g_comb
            always_comb begin
                nan_out = hit && rst_n;
                nan_res = rst_n ? res_c : '0;
                invalid = inv && rst_n;
            end
        end
    endgenerate
endmodule

// File: rtl/nanp_checker.sv
module nanp_checker
    import nanp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_mode,
    input logic              unary,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic              nan_out,
    input logic [WORD_W-1:0] nan_res,
    input logic              invalid
);
    function automatic logic f_nan(input logic [WORD_W-1:0] w);
        return (&w[EXP_HI:EXP_LO]) && (|w[FRAC_W-1:0]);
    endfunction

    function automatic logic f_snan(input logic [WORD_W-1:0] w);
        return f_nan(w) && !w[QBIT];
    endfunction

    localparam logic [WORD_W-1:0] QMASK = WORD_W'(1) << QBIT;

    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_chk
            AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                nan_out |-> (nan_res[QBIT] && (&nan_res[EXP_HI:EXP_LO]))); // R2
            AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !nan_out |-> (nan_res == '0 && !invalid)); // R9
            AST_INVALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                primed |-> (invalid == (f_snan($past(opa)) ||
                            (!$past(unary) && f_snan($past(opb)))))); // R3
            AST_UNARY_A: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(unary)) |->
                    (nan_out == f_nan($past(opa)))); // R8
            AST_VECTOR_A: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(conv_mode) && f_nan($past(opa))) |->
                    (nan_res == ($past(opa) | QMASK))); // R5
            AST_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && nan_out) |->
                    (nan_res == ($past(opa) | QMASK) ||
                     nan_res == ($past(opb) | QMASK))); // R10
        end
    endgenerate
endmodule

bind nan_prop_select nanp_checker #(.REG_OUT(REG_OUT)) u_nanp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_mode(conv_mode),
    .unary    (unary),
    .opa      (opa),
    .opb      (opb),
    .nan_out  (nan_out),
    .nan_res  (nan_res),
    .invalid  (invalid)
);

// File: tb/tb_nan_prop_select.sv
module tb_nan_prop_select;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_mode = 1'b0;
    logic        unary = 1'b0;
    logic [31:0] opa = 32'h7f80_0001;
    logic [31:0] opb = 32'h7fc0_0002;
    logic        nan_out;
    logic [31:0] nan_res;
    logic        invalid;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // expected values for the operation currently in the output register
    bit          exp_valid = 1'b0;
    logic        e_nan;
    logic        e_inv;
    logic [31:0] e_res;
    string       e_tag;

    nan_prop_select #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .conv_mode(conv_mode), .unary(unary),
        .opa(opa), .opb(opb), .nan_out(nan_out), .nan_res(nan_res),
        .invalid(invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_nan(input logic [31:0] w);
        return (w[30:23] == 8'hff) && (w[22:0] != 0);
    endfunction

    function automatic bit is_sig(input logic [31:0] w);
        return is_nan(w) && (w[22] == 1'b0);
    endfunction

    function automatic logic [31:0] quiet(input logic [31:0] w);
        return w | 32'h0040_0000;
    endfunction

    // behavioural reference: returns {nan, invalid, result} and a tag
    task automatic model(input logic m, input logic u,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic n, output logic iv,
                         output logic [31:0] r, output string tag);
        bit an = is_nan(a);
        bit bn = is_nan(b) && !u;
        iv = is_sig(a) || (!u && is_sig(b));
        n = an || bn;
        r = 32'h0;
        if (u) begin
            tag = "R8";
            if (an) r = quiet(a);
        end else if (!an && !bn) begin
            tag = "R9";
        end else if (an != bn) begin
            tag = "R4";
            r = an ? quiet(a) : quiet(b);
        end else if (m) begin
            tag = "R5";
            r = quiet(a);
        end else if (is_sig(a) != is_sig(b)) begin
            tag = "R6";
            r = is_sig(a) ? b : a;
        end else begin
            tag = "R7";
            if (b[22:0] > a[22:0]) r = quiet(b);
            else                   r = quiet(a);
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // at a falling edge: compare the registered result, then drive new inputs
    task automatic step(input logic m, input logic u,
                        input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        if (exp_valid) begin
            check("R1 nan_out", {31'b0, nan_out}, {31'b0, e_nan});
            check("R3 invalid", {31'b0, invalid}, {31'b0, e_inv});
            check(e_tag, nan_res, e_res);
            if (e_nan) check("R2 quiet bit", {31'b0, nan_res[22]}, 32'h1);
        end
        conv_mode = m; unary = u; opa = a; opb = b;
        model(m, u, a, b, e_nan, e_inv, e_res, e_tag);
        e_tag = {e_tag, " (R10 latency)"};
        exp_valid = 1'b1;
    endtask

    function automatic logic [31:0] gen(input int kind, input logic [31:0] rnd);
        logic [31:0] w = rnd;
        case (kind)
            0: begin
                if (w[30:23] == 8'hff) w[30:23] = 8'h80;
            end
            1: w = {rnd[31], 8'hff, 23'h0};
            2: begin
                w[30:23] = 8'hff; w[22] = 1'b0;
                if (w[21:0] == 0) w[0] = 1'b1;
            end
            default: begin
                w[30:23] = 8'hff; w[22] = 1'b1;
            end
        endcase
        return w;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d",
                     cycles, WATCHDOG);
            $display("  End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state, R10
        repeat (2) @(negedge clk);
        check("R10 reset nan_out", {31'b0, nan_out}, 32'h0);
        check("R10 reset nan_res", nan_res, 32'h0);
        check("R10 reset invalid", {31'b0, invalid}, 32'h0);
        rst_n = 1'b1;

        // directed corners
        step(0, 0, 32'h3f80_0000, 32'h4000_0000); // R9 ordinary pair
        step(0, 0, 32'h7f80_0000, 32'hff80_0000); // R9 infinities are not NaN
        step(0, 0, 32'h7f80_0001, 32'h3f80_0000); // R4 sNaN with ordinary
        step(1, 0, 32'h3f80_0000, 32'hffc1_2345); // R4 qNaN in B
        step(0, 0, 32'h7f80_0010, 32'h7fc0_0001); // R6 s vs q, q wins
        step(0, 0, 32'hffc0_0005, 32'h7f80_7000); // R6 q in A
        step(1, 0, 32'h7f80_0010, 32'h7fc0_0001); // R5 A wins, quieted
        step(0, 0, 32'h7f80_0003, 32'hff80_0009); // R7 two sNaN, B larger
        step(0, 0, 32'h7fc0_0009, 32'hffc0_0009); // R7 tie, A
        step(0, 0, 32'hffc0_0100, 32'h7fc0_0011); // R7 two qNaN, A larger
        step(1, 0, 32'h7fc0_0001, 32'h7fff_ffff); // R5 vector two qNaN
        step(0, 1, 32'h3f80_0000, 32'h7f80_0001); // R8 B sNaN ignored
        step(1, 1, 32'h7f80_0002, 32'h7fc0_0000); // R8 A sNaN unary
        step(0, 1, 32'hffc0_0abc, 32'h7f80_0001); // R8 A qNaN unary

        for (int i = 0; i < N_RAND; i++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            logic [31:0] a = gen(int'($urandom_range(0, 3)), ra);
            logic [31:0] b = gen(int'($urandom_range(0, 3)), rb);
            if ($urandom_range(0, 7) == 0) b[22:0] = a[22:0] ^ {b[22], 22'h0};
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0), a, b);
        end
        step(0, 0, 32'h0, 32'h0);
        @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule